// File: doc/BRIEF.md
# SD Card Clock Generator

This block derives the clock driven to an SD or MMC card from a fixed host clock (nominally 24 MHz). The card clock is either the host clock itself, passed through a gate, or the host clock divided by a power of two from 2 up to 512. With a 24 MHz host clock this gives rates that double from 46875 Hz up to 24 MHz. Two enables must both be set for the clock to reach the card. Software sets the card clock enable first and the output enable second when starting the clock. It clears them in the opposite order when stopping it.

Software programs the block through a small word-wide write port with two register slots and reads both slots back on a separate select. A new setting is not applied on the write. It is held as pending and handed to the clock path only while the card clock is low. A change of rate, mode or enable therefore never cuts a high phase short and never produces a runt pulse. While either enable is clear, the card clock stays low and the divide counter is held at zero. After enabling, the clock starts with a full low phase.

Top module: `sdclk_gen`

## Requirements
- R1: A synchronous active-high reset clears both enables and the bypass bit, and sets the rate field to 0x80 (divide by 512). After reset, slot 0 reads 0x0080, slot 1 reads 0x0000, and card_clk is low.
- R2: A write to slot 0 stores the rate field from bits 7:0, the card clock enable from bit 8 and the bypass bit from bit 9. A write to slot 1 stores the output enable from bit 8. Reading a slot returns these bits in the same positions, with every other bit zero.
- R3: With bypass clear and exactly bit k of the rate field set, card_clk has a period of 2^(k+2) host cycles and is high for half of it.
- R4: With bypass clear and the rate field zero, card_clk toggles on every host clock edge (divide by 2).
- R5: With bypass clear and more than one bit of the rate field set, card_clk divides by 512.
- R6: With bypass set and both enables set, card_clk is high during every high phase of the host clock and low during every low phase, whatever the rate field holds.
- R7: While the card clock enable or the output enable is clear, card_clk stays low. When a write enables a divide-by-N setting from the stopped state, card_clk rises on the (N/2+1)-th host edge after the edge that stores the write.
- R8: A new setting is applied only while card_clk is low. A write that arrives during a high phase leaves that phase at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write slot: 0 rate/enable/bypass word, 1 output enable word |
| wr_data | input | 16 | Write data |
| rd_sel | input | 1 | Read slot select |
| rd_data | output | 16 | Read data of the selected slot |
| card_clk | output | 1 | Clock to the card |

## Verification
A register write and a high phase of the card clock can fall in the same cycle. In that case the write must wait for the clock to go low rather than cut the pulse short. The bench provokes this at divide by 512. It detects the first sample after a rising edge and drives a disabling write on that same cycle. It then counts high samples and expects exactly 256, followed by a quiet output. The reverse collision, enabling from the stopped state, is judged by the exact edge on which the first rise appears.

// File: rtl/sdclk_pkg.sv
`timescale 1ns/1ps
package sdclk_pkg;
    parameter int unsigned SEL_W  = 8;
    parameter int unsigned WORD_W = 16;
    localparam int unsigned EN_BIT  = SEL_W;
    localparam int unsigned BYP_BIT = SEL_W + 1;
    localparam int unsigned EXP_W   = $clog2(SEL_W + 2);

    typedef struct packed {
        logic             bypass;
        logic             card_en;
        logic             out_en;
        logic [SEL_W-1:0] sel;
    } clk_cfg_t;

    // log2 of the divide ratio: 1 for field zero, k+2 for one-hot bit k,
    // SEL_W+1 for any multi-hot field.
    function automatic logic [EXP_W-1:0] ratio_exp(input logic [SEL_W-1:0] sel);
        logic [EXP_W-1:0] e;
        e = EXP_W'(SEL_W + 1);
        if (sel == '0) begin
            e = EXP_W'(1);
        end else if ($countones(sel) == 1) begin
            for (int k = 0; k < SEL_W; k++) begin
                if (sel[k]) e = EXP_W'(k + 2);
            end
        end
        return e;
    endfunction
endpackage

// File: rtl/sdclk_regs.sv
`timescale 1ns/1ps
module sdclk_regs
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output clk_cfg_t          cfg_o
);
    localparam logic [SEL_W-1:0] SEL_SLOW = SEL_W'(1) << (SEL_W - 1);

    clk_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (!wr_sel) begin
                cfg_d.sel     = wr_data[SEL_W-1:0];
                cfg_d.card_en = wr_data[EN_BIT];
                cfg_d.bypass  = wr_data[BYP_BIT];
            end else begin
                cfg_d.out_en  = wr_data[EN_BIT];
            end
        end
        rd_data = '0;
        if (!rd_sel) begin
            rd_data[SEL_W-1:0] = cfg_q.sel;
            rd_data[EN_BIT]    = cfg_q.card_en;
            rd_data[BYP_BIT]   = cfg_q.bypass;
        end else begin
            rd_data[EN_BIT]    = cfg_q.out_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{bypass: 1'b0, card_en: 1'b0, out_en: 1'b0, sel: SEL_SLOW};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    assert_slot0_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_sel) |=> (cfg_q.sel == $past(wr_data[SEL_W-1:0]) &&
                                cfg_q.card_en == $past(wr_data[EN_BIT]) &&
                                cfg_q.bypass == $past(wr_data[BYP_BIT])));

    assert_slot1_store_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel) |=> (cfg_q.out_en == $past(wr_data[EN_BIT])));
endmodule

// File: rtl/sdclk_handoff.sv
`timescale 1ns/1ps
module sdclk_handoff
    import sdclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_cfg_t cfg_req,
    input  logic     div_out_i,
    output clk_cfg_t cfg_app,
    output logic     apply_o,
    output logic     gate_o
);
    localparam logic [SEL_W-1:0] SEL_SLOW = SEL_W'(1) << (SEL_W - 1);

    typedef struct packed {
        clk_cfg_t app;
    } ho_t;

    ho_t  st_d, st_q;
    logic pending;
    logic gate_d, gate_q;

    always_comb begin
        st_d    = st_q;
        pending = (cfg_req != st_q.app);
        apply_o = pending && !div_out_i && !gate_q;
        if (apply_o) st_d.app = cfg_req;
        gate_d  = st_q.app.bypass && st_q.app.card_en && st_q.app.out_en && !pending;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.app <= '{bypass: 1'b0, card_en: 1'b0, out_en: 1'b0, sel: SEL_SLOW};
        end else begin
            st_q <= st_d;
        end
    end

    // Bypass gate moves only while the host clock is low.
    always_ff @(negedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate_d;
    end

    assign cfg_app = st_q.app;
    assign gate_o  = gate_q;

    assert_apply_low_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.app) |-> $past(!div_out_i && !gate_q));

    assert_quiet_off_R7: assert property (@(posedge clk) disable iff (rst)
        !(st_q.app.card_en && st_q.app.out_en) |-> (!div_out_i && !gate_q));
endmodule

// File: rtl/sdclk_div.sv
`timescale 1ns/1ps
module sdclk_div
    import sdclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] lim,
    output logic             div_out
);
    typedef struct packed {
        logic [SEL_W-1:0] cnt;
        logic             out;
    } dv_t;

    dv_t dv_d, dv_q;

    always_comb begin
        dv_d = dv_q;
        if (!run || restart) begin
            dv_d.cnt = '0;
            dv_d.out = 1'b0;
        end else if (dv_q.cnt == lim) begin
            dv_d.cnt = '0;
            dv_d.out = !dv_q.out;
        end else begin
            dv_d.cnt = dv_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) dv_q <= '0;
        else     dv_q <= dv_d;
    end

    assign div_out = dv_q.out;

    assert_held_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!dv_q.out && dv_q.cnt == '0));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (run && !restart) |-> (dv_q.cnt <= lim));
endmodule

// File: rtl/sdclk_gen.sv
`timescale 1ns/1ps
module sdclk_gen
    import sdclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic              card_clk
);
    clk_cfg_t         cfg_req, cfg_app;
    logic             apply, gate, div_out, run;
    logic [EXP_W-1:0] e;
    logic [SEL_W:0]   half;
    logic [SEL_W-1:0] lim;

    sdclk_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .rd_sel  (rd_sel),
        .rd_data (rd_data),
        .cfg_o   (cfg_req)
    );

    sdclk_handoff u_ho (
        .clk       (clk),
        .rst       (rst),
        .cfg_req   (cfg_req),
        .div_out_i (div_out),
        .cfg_app   (cfg_app),
        .apply_o   (apply),
        .gate_o    (gate)
    );

    always_comb begin
        e    = ratio_exp(cfg_app.sel);
        half = (SEL_W + 1)'(1) << (e - 1'b1);
        lim  = SEL_W'(half - 1'b1);
        run  = cfg_app.card_en && cfg_app.out_en && !cfg_app.bypass;
    end

    sdclk_div u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (apply),
        .lim     (lim),
        .div_out (div_out)
    );

    assign card_clk = div_out | (clk & gate);
endmodule

// File: tb/tb_sdclk_gen.sv
`timescale 1ns/1ps
module tb_sdclk_gen;
    localparam int CLK_P = 10;
    localparam int NVEC  = 11;
    // {slot0 word, slot1 word, expected period: 0 off, 1 bypass, else cycles}
    localparam logic [47:0] VECS [NVEC] = '{
        {16'h0101, 16'h0100, 16'd4},
        {16'h0102, 16'h0100, 16'd8},
        {16'h0104, 16'h0100, 16'd16},
        {16'h0110, 16'h0100, 16'd64},
        {16'h0180, 16'h0100, 16'd512},
        {16'h0100, 16'h0100, 16'd2},
        {16'h0103, 16'h0100, 16'd512},
        {16'h0304, 16'h0100, 16'd1},
        {16'h0101, 16'h0000, 16'd0},
        {16'h0001, 16'h0100, 16'd0},
        {16'h0240, 16'h0100, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        card_clk;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #(CLK_P/2) clk = !clk;

    sdclk_gen dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .card_clk(card_clk)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [15:0] d);
        @(negedge clk);
        rd_sel = sel;
        #1 d = rd_data;
    endtask

    task automatic measure(output int per);
        bit byp_ok = 1;
        int nr = 0;
        int r0 = 0, r1 = 0;
        logic prev = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #1; if (!card_clk) byp_ok = 0;
            @(negedge clk); #1; if (card_clk)  byp_ok = 0;
        end
        if (byp_ok) begin
            per = 1;
        end else begin
            for (int i = 0; i < 1200 && nr < 2; i++) begin
                @(posedge clk); #1;
                if (!prev && card_clk) begin
                    if (nr == 0) r0 = i; else r1 = i;
                    nr++;
                end
                prev = card_clk;
            end
            per = (nr == 2) ? (r1 - r0) : 0;
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic [15:0] d;
        int per, cnt;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        rd(1'b0, d); check("R1 slot0", d, 16'h0080);
        rd(1'b1, d); check("R1 slot1", d, 16'h0000);
        measure(per); check("R1 clk off", per, 0);

        // vector walk: R2..R7
        for (int v = 0; v < NVEC; v++) begin
            wr(1'b0, VECS[v][47:32]);
            wr(1'b1, VECS[v][31:16]);
            rd(1'b0, d); check("R2 slot0 readback", d, VECS[v][47:32] & 16'h03FF);
            rd(1'b1, d); check("R2 slot1 readback", d, VECS[v][31:16] & 16'h0100);
            repeat (300) @(posedge clk);
            measure(per);
            // R3 R4 R5 R6 R7 period by rate setting
            check($sformatf("R3/R4/R5/R6/R7 period vec %0d", v), per, VECS[v][15:0]);
        end

        // R8: write lands during a high phase at divide by 512
        wr(1'b1, 16'h0100);
        wr(1'b0, 16'h0180);
        repeat (600) @(posedge clk);
        begin
            logic prev = 1'b1;
            for (int i = 0; i < 1200; i++) begin
                @(posedge clk); #1;
                if (!prev && card_clk) break;
                prev = card_clk;
            end
        end
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h0080;
        @(posedge clk); #1;
        wr_en = 1'b0;
        cnt = 1;
        if (card_clk) begin
            cnt = 2;
            for (int i = 0; i < 600; i++) begin
                @(posedge clk); #1;
                if (!card_clk) break;
                cnt++;
            end
        end
        check("R8 high phase kept", cnt, 256);
        measure(per); check("R7 stays low after disable", per, 0);

        // R7: enabling divide by 8 from stop, first rise on 5th edge
        wr(1'b0, 16'h0102);
        cnt = 0;
        for (int i = 0; i < 40; i++) begin
            @(posedge clk); #1;
            if (card_clk) break;
            cnt++;
        end
        check("R7 first low phase", cnt, 4);
        measure(per); check("R3 divide by 8 after start", per, 8);

        // R6: bypass ignores rate field
        wr(1'b0, 16'h0300);
        repeat (20) @(posedge clk);
        measure(per); check("R6 bypass field zero", per, 1);

        // R1: reset while running
        @(negedge clk); rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        rd(1'b0, d); check("R1 slot0 after rerun reset", d, 16'h0080);
        rd(1'b1, d); check("R1 slot1 after rerun reset", d, 16'h0000);
        measure(per); check("R1 clk off after reset", per, 0);

        summary();
    end
endmodule